// File: doc/BRIEF.md
# Bus-Mastered Memory Refresh Sequencer

This block turns periodic refresh ticks into single byte-read bus cycles that step through a programmable range of refresh addresses. An interval timer outside the block drives an active-low tick line. The block reacts to each high-to-low transition. It raises a bus request together with a bus-clear request, using the same arbitration a DMA channel uses. It waits for the grant, then runs one byte read and releases the bus.

The byte lane for each read comes from the lowest address bit. Odd addresses use the lower data strobe and even addresses use the upper one. Each refresh cycle carries its own function-code value, so outside logic can tell refresh cycles from other DMA traffic. When a cycle ends normally, the refresh pointer moves to the next address. The pointer wraps from the end address back to the base address.

A bus error ends the cycle without moving the pointer, so the next tick retries the same location. A bus error also writes a fixed channel code into a 16-bit error-channel register. That code is shared with an unrelated receive DMA channel. The block holds at most one tick beyond the one being served. Any tick beyond that is counted as an overrun.

Top module: `refreshEngine`

## Requirements
- R1: After reset, `busReq` and `busClr` are low, `asN`, `udsN` and `ldsN` are high, `fcOut` is 0, `errChan` is 0 and `overrunCnt` is 0.
- R2: Each high-to-low transition of `reqN` produces exactly one refresh cycle. Holding `reqN` low, or raising it, produces none.
- R3: `busReq` and `busClr` are raised when a request is pending. `asN` stays high until `busGrant` is seen. `asN` is then held low until `dtackN` or `berrN` is sampled low, and it is high again on the following cycle.
- R4: During a cycle, exactly one data strobe is low. An odd address (bit 0 = 1) drives `ldsN` low, and an even address drives `udsN` low. Both strobes are high outside a cycle.
- R5: `fcOut` equals the refresh function code (default 3'b101) while `asN` is low, and 0 otherwise.
- R6: The first cycle after reset uses `cfgBase`. Each normally completed cycle adds one to the address. A completed cycle at `cfgEnd` wraps the address back to `cfgBase`.
- R7: A cycle that ends with `berrN` low writes 16'h0001 into `errChan` and leaves the refresh address unchanged. A bus error wins over `dtackN` in the same cycle.
- R8: Up to two requests are held, counting the one being served. A falling edge that arrives while two are held increments `overrunCnt`, which saturates, and is otherwise dropped.
- R9: A falling edge of `reqN` in the same cycle a refresh completes is counted, so a further refresh cycle follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqN | input | 1 | Refresh tick; a falling edge requests one refresh |
| cfgBase | input | AW | First address of the refresh range |
| cfgEnd | input | AW | Last address of the refresh range |
| busGrant | input | 1 | Bus granted to this block |
| dtackN | input | 1 | Active-low data acknowledge |
| berrN | input | 1 | Active-low bus error |
| busReq | output | 1 | Bus request |
| busClr | output | 1 | Bus-clear request to other masters |
| asN | output | 1 | Active-low address strobe |
| udsN | output | 1 | Active-low upper data strobe |
| ldsN | output | 1 | Active-low lower data strobe |
| fcOut | output | 3 | Function code of the current cycle |
| addrOut | output | AW | Current refresh address |
| errChan | output | 16 | Error-channel register |
| overrunCnt | output | OVW | Count of dropped requests, saturating |

## Verification
Two events can land in the same clock: a new tick edge being detected and a refresh cycle completing. In that clock the pending count is decremented and incremented at once. The bench lowers `reqN` on the same edge that it lowers `dtackN`. It then judges the result by whether a second, fully handshaked cycle follows at the next expected address. A second same-cycle collision is a bus error together with an acknowledge. The bench expects that case to be treated as an error: the error code is written and the address is held.

// File: rtl/refrPkg.sv
package refrPkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_CYC
  } refrState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic dsEn;   // a data strobe is driven this cycle
    logic fin;    // cycle completed normally
    logic err;    // cycle completed with bus error
  } pathCtl_t;
endpackage

// File: rtl/refrCtrl.sv
module refrCtrl
  import refrPkg::*;
#(
  parameter int OVW = 8,
  parameter logic [2:0] REFR_FC = 3'b101
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           reqN,
  input  logic           busGrant,
  input  logic           dtackN,
  input  logic           berrN,
  output logic           busReq,
  output logic           busClr,
  output logic           asN,
  output logic [2:0]     fcOut,
  output pathCtl_t       ctl,
  output logic [OVW-1:0] overrunCnt
);
  localparam logic [1:0] PEND_MAX = 2'd2;
  localparam logic [OVW-1:0] OV_SAT = {OVW{1'b1}};

  refrState_t stateQ, stateNext;
  logic reqQ;
  logic [1:0] pendQ, pendNext;
  logic fallEdge, cycEnd, dropReq;

  assign fallEdge = reqQ & ~reqN;
  assign cycEnd   = (stateQ == ST_CYC) && (!dtackN || !berrN);
  assign dropReq  = fallEdge && (pendQ == PEND_MAX) && !cycEnd;

  always_comb begin
    pendNext = pendQ;
    if (cycEnd) pendNext = pendNext - 2'd1;
    if (fallEdge && !dropReq) pendNext = pendNext + 2'd1;
  end

  always_comb begin
    stateNext = stateQ;
    unique case (stateQ)
      ST_IDLE: if (pendQ != 2'd0) stateNext = ST_REQ;
      ST_REQ:  if (busGrant) stateNext = ST_CYC;
      ST_CYC:  if (cycEnd) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      reqQ       <= 1'b1;
      pendQ      <= 2'd0;
      overrunCnt <= '0;
    end else begin
      stateQ <= stateNext;
      reqQ   <= reqN;
      pendQ  <= pendNext;
      if (dropReq && overrunCnt != OV_SAT) overrunCnt <= overrunCnt + 1'b1;
    end
  end

  assign busReq  = (stateQ != ST_IDLE);
  assign busClr  = (stateQ != ST_IDLE);
  assign asN     = (stateQ != ST_CYC);
  assign fcOut   = (stateQ == ST_CYC) ? REFR_FC : 3'b000;
  assign ctl.dsEn = (stateQ == ST_CYC);
  assign ctl.fin  = cycEnd && berrN;
  assign ctl.err  = cycEnd && !berrN;

  // R8: never more than two requests held
  assert_pend_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    pendQ <= PEND_MAX);

  // R3: address strobe only begins after a grant was seen
  assert_grant_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(asN) |-> $past(busGrant));

  // R3: strobe released the cycle after acknowledge or bus error
  assert_release_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!asN && (!dtackN || !berrN)) |=> asN);

  // R5: function code only during a strobed cycle
  assert_fc_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    (fcOut != 3'b000) |-> !asN);

  // R3: bus request held for the whole strobed cycle
  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    !asN |-> busReq);
endmodule

// File: rtl/refrPath.sv
module refrPath
  import refrPkg::*;
#(
  parameter int AW = 16,
  parameter int ERRW = 16,
  parameter logic [ERRW-1:0] ERR_CODE = 16'h0001
) (
  input  logic            clk,
  input  logic            rstN,
  input  pathCtl_t        ctl,
  input  logic [AW-1:0]   cfgBase,
  input  logic [AW-1:0]   cfgEnd,
  output logic [AW-1:0]   addrOut,
  output logic            udsN,
  output logic            ldsN,
  output logic [ERRW-1:0] errChan
);
  logic [AW-1:0] addrQ;
  logic          addrLive;
  logic [AW-1:0] addrStep;

  // before the first completed cycle, the pointer sits at the base
  assign addrOut  = addrLive ? addrQ : cfgBase;
  assign addrStep = (addrOut == cfgEnd) ? cfgBase : addrOut + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      addrLive <= 1'b0;
      errChan  <= '0;
    end else begin
      if (ctl.fin) begin
        addrQ    <= addrStep;
        addrLive <= 1'b1;
      end
      if (ctl.err) errChan <= ERR_CODE;
    end
  end

  assign udsN = !(ctl.dsEn && !addrOut[0]);
  assign ldsN = !(ctl.dsEn &&  addrOut[0]);

  // R4: byte read drives exactly one lane
  assert_one_lane_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.dsEn |-> ($countones({udsN, ldsN}) == 1));

  // R7: bus error leaves the pointer where it was
  assert_berr_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.err |=> ($stable(addrQ) && $stable(addrLive)));

  // R7: error channel gets the fixed code
  assert_err_code_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.err |=> (errChan == ERR_CODE));

  // R6: completion at the end address wraps to the base
  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.fin && addrOut == cfgEnd) ##1 $stable(cfgBase) |-> (addrOut == cfgBase));
endmodule

// File: rtl/refreshEngine.sv
module refreshEngine
  import refrPkg::*;
#(
  parameter int AW = 16,
  parameter int OVW = 8,
  parameter logic [2:0] REFR_FC = 3'b101
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           reqN,
  input  logic [AW-1:0]  cfgBase,
  input  logic [AW-1:0]  cfgEnd,
  input  logic           busGrant,
  input  logic           dtackN,
  input  logic           berrN,
  output logic           busReq,
  output logic           busClr,
  output logic           asN,
  output logic           udsN,
  output logic           ldsN,
  output logic [2:0]     fcOut,
  output logic [AW-1:0]  addrOut,
  output logic [15:0]    errChan,
  output logic [OVW-1:0] overrunCnt
);
  pathCtl_t ctl;

  refrCtrl #(.OVW(OVW), .REFR_FC(REFR_FC)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqN(reqN), .busGrant(busGrant),
    .dtackN(dtackN), .berrN(berrN), .busReq(busReq), .busClr(busClr),
    .asN(asN), .fcOut(fcOut), .ctl(ctl), .overrunCnt(overrunCnt)
  );

  refrPath #(.AW(AW), .ERRW(16), .ERR_CODE(16'h0001)) u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cfgBase(cfgBase), .cfgEnd(cfgEnd),
    .addrOut(addrOut), .udsN(udsN), .ldsN(ldsN), .errChan(errChan)
  );

  // R4: lane follows address parity at the ports
  assert_lane_parity_R4: assert property (@(posedge clk) disable iff (!rstN)
    !asN |-> (ldsN == !addrOut[0]) && (udsN == addrOut[0]));
endmodule

// File: tb/sim_refreshEngine.sv
module sim_refreshEngine;
  localparam int AW = 4;
  localparam int OVW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqN = 1'b1;
  logic [AW-1:0] cfgBase = '0, cfgEnd = '0;
  logic busGrant = 1'b0, dtackN = 1'b1, berrN = 1'b1;
  logic busReq, busClr, asN, udsN, ldsN;
  logic [2:0] fcOut;
  logic [AW-1:0] addrOut;
  logic [15:0] errChan;
  logic [OVW-1:0] overrunCnt;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [AW-1:0] expAddr;

  always #2.5 clk = ~clk;

  refreshEngine #(.AW(AW), .OVW(OVW)) u0 (
    .clk(clk), .rstN(rstN), .reqN(reqN), .cfgBase(cfgBase), .cfgEnd(cfgEnd),
    .busGrant(busGrant), .dtackN(dtackN), .berrN(berrN), .busReq(busReq),
    .busClr(busClr), .asN(asN), .udsN(udsN), .ldsN(ldsN), .fcOut(fcOut),
    .addrOut(addrOut), .errChan(errChan), .overrunCnt(overrunCnt)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset(input int b, input int e);
    rstN = 1'b0; reqN = 1'b1; busGrant = 1'b0; dtackN = 1'b1; berrN = 1'b1;
    cfgBase = AW'(b); cfgEnd = AW'(e);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expAddr = AW'(b);
    // R1 reset state
    chk(busReq === 1'b0 && busClr === 1'b0, "R1", "bus request", busReq, 0);
    chk(asN === 1'b1 && udsN === 1'b1 && ldsN === 1'b1, "R1", "strobes",
        {asN, udsN, ldsN}, 7);
    chk(fcOut === 3'd0, "R1", "fc", fcOut, 0);
    chk(errChan === 16'd0 && overrunCnt === '0, "R1", "err/ovr", errChan, 0);
  endtask

  task automatic pulse();
    reqN = 1'b0;
    @(negedge clk);
    reqN = 1'b1;
    @(negedge clk);
  endtask

  // run one handshake; err/ack pick the ending, edgeEnd drops reqN at the end
  task automatic serve(input bit useErr, input bit useAck, input bit edgeEnd);
    int n;
    n = 0;
    while (busReq !== 1'b1 && n < 40) begin @(negedge clk); n++; end
    chk(busReq === 1'b1, "R2", "request raised", busReq, 1);
    chk(busClr === 1'b1 && asN === 1'b1, "R3", "clear before grant",
        {busClr, asN}, 3);
    repeat (2) @(negedge clk);
    chk(asN === 1'b1, "R3", "no strobe without grant", asN, 1);
    busGrant = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(asN === 1'b0, "R3", "strobe after grant", asN, 0);
    chk(addrOut === expAddr, "R6", "address", addrOut, expAddr);
    chk(ldsN === ~expAddr[0] && udsN === expAddr[0], "R4", "lane",
        {udsN, ldsN}, {expAddr[0], ~expAddr[0]});
    chk(fcOut === 3'b101, "R5", "fc in cycle", fcOut, 5);
    @(negedge clk);
    chk(asN === 1'b0, "R3", "strobe held", asN, 0);
    if (useErr) berrN = 1'b0;
    if (useAck) dtackN = 1'b0;
    if (edgeEnd) reqN = 1'b0;
    @(negedge clk);
    chk(asN === 1'b1 && udsN === 1'b1 && ldsN === 1'b1, "R3", "release",
        {asN, udsN, ldsN}, 7);
    chk(fcOut === 3'd0, "R5", "fc after cycle", fcOut, 0);
    berrN = 1'b1; dtackN = 1'b1; busGrant = 1'b0; reqN = 1'b1;
    if (useErr) chk(errChan === 16'h0001, "R7", "error code", errChan, 1);
    else expAddr = (expAddr == cfgEnd) ? cfgBase : expAddr + 1'b1;
  endtask

  task automatic quiet(input string req);
    repeat (20) @(negedge clk);
    chk(busReq === 1'b0, req, "no extra request", busReq, 0);
  endtask

  initial begin
    int bases[4];
    int ends[4];
    bases = '{3, 0, 5, 14};
    ends  = '{9, 15, 5, 15};
    foreach (bases[i]) begin
      doReset(bases[i], ends[i]);
      for (int k = 0; k < 2 * (ends[i] - bases[i] + 1) + 1; k++) begin
        pulse();
        serve(1'b0, 1'b1, 1'b0);
      end
      quiet("R2");
    end

    // R2: holding low or rising gives nothing further
    doReset(3, 9);
    reqN = 1'b0;
    serve(1'b0, 1'b1, 1'b0);
    reqN = 1'b0;
    quiet("R2");
    reqN = 1'b1;
    quiet("R2");

    // R8: third edge while two held is dropped and counted
    pulse(); pulse(); pulse();
    chk(overrunCnt === 8'd1, "R8", "overrun count", overrunCnt, 1);
    serve(1'b0, 1'b1, 1'b0);
    serve(1'b0, 1'b1, 1'b0);
    quiet("R8");

    // R9: edge in the completion cycle is kept
    pulse();
    serve(1'b0, 1'b1, 1'b1);
    serve(1'b0, 1'b1, 1'b0);
    quiet("R9");

    // R7: bus error holds address; retry then reaches same location
    pulse();
    serve(1'b1, 1'b0, 1'b0);
    pulse();
    serve(1'b0, 1'b1, 1'b0);
    // R7: error together with acknowledge counts as error
    pulse();
    serve(1'b1, 1'b1, 1'b0);
    pulse();
    serve(1'b0, 1'b1, 1'b0);
    quiet("R7");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule